// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between instruction fetch and the execute stage of a small 16-bit stack machine. It takes instruction bytes one per cycle under a valid/ready handshake and assembles complete instructions. It then presents each instruction as a decoded record: a 5-bit operation, an implied-DUP flag, a 16-bit constant with its valid flag, or a CALL request with a 16-bit byte target. The record also carries the number of bytes consumed, which the fetch unit adds to its program counter.

The first byte fixes the length. Its top bit marks a two-byte CALL. Otherwise bits 6:5 select one of four classes: a plain stack operation, the same operation preceded by an implied DUP, the operation with a following 8-bit constant, or the operation with a following 16-bit constant. Every instruction starts at an even address. The one-byte and three-byte forms are therefore followed by a filler byte. The block absorbs that filler byte, so the byte count it reports is always 2 or 4.

Each decoded record stays on the outputs until the consumer takes it. While a record is held, no further byte is accepted, except in the cycle in which that record is taken.

Top module: `instr_predecode`

## Requirements
- R1: After reset, ins_valid_o is 0 and byte_ready_o is 1.
- R2: A first byte 000ooooo gives op_o = ooooo, dup_o = 0, const_valid_o = 0, call_o = 0 and len_o = 2. The second (filler) byte is accepted and its value has no effect on any output.
- R3: A first byte 001ooooo gives the same record as R2, except that dup_o = 1.
- R4: A first byte 010ooooo takes one further byte k. It gives const_valid_o = 1, const_o = k sign-extended to 16 bits (bit 7 of k copied into bits 15:8), dup_o = 0 and len_o = 2.
- R5: A first byte 011ooooo takes three further bytes lo, hi, filler. It gives const_valid_o = 1, const_o = {hi, lo} and len_o = 4. The filler value has no effect.
- R6: A first byte 1aaaaaaa followed by byte b gives call_o = 1, call_target_o = {aaaaaaa, b, 1'b0}, len_o = 2, op_o = 0, dup_o = 0 and const_valid_o = 0.
- R7: While ins_valid_o = 1 and ins_ready_i = 0, every record output keeps its value into the next cycle, and byte_ready_o = 0.
- R8: byte_ready_o = 1 whenever ins_valid_o = 0 or ins_ready_i = 1. With ready held high and bytes supplied every cycle, a new record starts every instruction-length cycles. Gaps in byte_valid_i do not corrupt the record being assembled.
- R9: ins_valid_o rises in the cycle after the last byte of an instruction is accepted. It falls in the cycle after a handshake, unless another instruction completes in that same handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Instruction byte from fetch |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_ready_o | output | 1 | Block accepts byte_i this cycle |
| ins_valid_o | output | 1 | Decoded record is present |
| ins_ready_i | input | 1 | Consumer takes the record this cycle |
| op_o | output | 5 | Operation field |
| dup_o | output | 1 | Implied DUP before the operation |
| const_o | output | 16 | Constant operand |
| const_valid_o | output | 1 | const_o is meaningful |
| call_o | output | 1 | Record is a CALL |
| call_target_o | output | 16 | CALL byte target |
| len_o | output | 3 | Bytes consumed (2 or 4) |

## Verification
The bench concentrates on the byte that decides the length. A design that judged the length from a stale byte would mis-frame every later instruction, and the reference model would show this as a cascade of op mismatches. Filler bytes and CALL fields get random values. A design that let a filler byte leak into const_o, or that dropped the CALL's top field bit or its doubling, would produce wrong constants or targets. Stall cycles on both sides check that a held record never changes and that no byte is swallowed during a hold. Constants with bit 7 set catch a zero-extended 8-bit constant and a byte-swapped 16-bit one.

// File: rtl/predec_pkg.sv
package predec_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int OP_W    = 5;
  localparam int MAX_LEN = 4;
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam int LEN_W   = $clog2(MAX_LEN) + 1;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'b00,
    CLS_DUP   = 2'b01,
    CLS_K8    = 2'b10,
    CLS_K16   = 2'b11
  } cls_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic              dup;
    logic [WORD_W-1:0] kval;
    logic              kvld;
    logic              call;
    logic [WORD_W-1:0] tgt;
    logic [LEN_W-1:0]  len;
  } rec_t;
endpackage

// File: rtl/predec_len.sv
module predec_len
  import predec_pkg::*;
(
  input  logic [BYTE_W-1:0] first_i,
  output logic [LEN_W-1:0]  len_o
);
  // even alignment: 1- and 3-byte forms carry a filler byte
  always_comb begin
    if (first_i[BYTE_W-1])                    len_o = LEN_W'(2);
    else if (cls_e'(first_i[6:5]) == CLS_K16) len_o = LEN_W'(4);
    else                                      len_o = LEN_W'(2);
  end
endmodule

// File: rtl/predec_fields.sv
module predec_fields
  import predec_pkg::*;
#(
  parameter bit SIGN_K8 = 1'b1
) (
  input  logic [MAX_LEN-1:0][BYTE_W-1:0] bytes_i,
  output rec_t                           rec_o
);
  logic [LEN_W-1:0]  len;
  logic [WORD_W-1:0] k8_ext;
  cls_e              cls;
  logic              is_call;

  predec_len u_len (.first_i(bytes_i[0]), .len_o(len));

  generate
    if (SIGN_K8) begin : g_sext
      assign k8_ext = {{(WORD_W-BYTE_W){bytes_i[1][BYTE_W-1]}}, bytes_i[1]};
    end else begin : g_zext
      assign k8_ext = {{(WORD_W-BYTE_W){1'b0}}, bytes_i[1]};
    end
  endgenerate

  assign is_call = bytes_i[0][BYTE_W-1];
  assign cls     = cls_e'(bytes_i[0][6:5]);

  always_comb begin
    rec_o     = '0;
    rec_o.len = len;
    if (is_call) begin
      rec_o.call = 1'b1;
      rec_o.tgt  = {bytes_i[0][BYTE_W-2:0], bytes_i[1], 1'b0};
    end else begin
      rec_o.op = bytes_i[0][OP_W-1:0];
      unique case (cls)
        CLS_PLAIN: ;
        CLS_DUP:   rec_o.dup = 1'b1;
        CLS_K8: begin
          rec_o.kvld = 1'b1;
          rec_o.kval = k8_ext;
        end
        CLS_K16: begin
          rec_o.kvld = 1'b1;
          rec_o.kval = {bytes_i[2], bytes_i[1]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    a_r6_call_len: assert (!rec_o.call || (rec_o.len == LEN_W'(2) && !rec_o.kvld && !rec_o.dup));
  end
endmodule

// File: rtl/instr_predecode.sv
module instr_predecode
  import predec_pkg::*;
#(
  parameter bit SIGN_K8 = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              ins_valid_o,
  input  logic              ins_ready_i,
  output logic [OP_W-1:0]   op_o,
  output logic              dup_o,
  output logic [WORD_W-1:0] const_o,
  output logic              const_valid_o,
  output logic              call_o,
  output logic [WORD_W-1:0] call_target_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [MAX_LEN-1:0][BYTE_W-1:0] buf_q;
  logic [CNT_W-1:0]               cnt_q;
  logic                           vld_q;
  logic [BYTE_W-1:0]              head;
  logic [LEN_W-1:0]               need;
  logic                           take, last;
  rec_t                           rec;

  assign byte_ready_o = !vld_q || ins_ready_i;
  assign take         = byte_valid_i && byte_ready_o;
  assign head         = (cnt_q == '0) ? byte_i : buf_q[0];

  predec_len u_need (.first_i(head), .len_o(need));

  assign last = take && ((LEN_W'(cnt_q) + LEN_W'(1)) == need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (take) buf_q[cnt_q] <= byte_i;
      if (vld_q && ins_ready_i) vld_q <= 1'b0;
      if (last) begin
        vld_q <= 1'b1;
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  predec_fields #(.SIGN_K8(SIGN_K8)) u_fields (.bytes_i(buf_q), .rec_o(rec));

  assign ins_valid_o   = vld_q;
  assign op_o          = rec.op;
  assign dup_o         = rec.dup;
  assign const_o       = rec.kval;
  assign const_valid_o = rec.kvld;
  assign call_o        = rec.call;
  assign call_target_o = rec.tgt;
  assign len_o         = rec.len;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_ready_i |=> ins_valid_o &&
      $stable({op_o, dup_o, const_o, const_valid_o, call_o, call_target_o, len_o}));

  a_r9_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_valid_o) |-> $past(take));

  a_r8_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (LEN_W'(cnt_q) < need));

  a_r2_len_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> (len_o == LEN_W'(2) || len_o == LEN_W'(4)));
endmodule

// File: tb/instr_predecode_test.sv
module instr_predecode_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        byte_v = 1'b0;
  logic        byte_rdy;
  logic        ins_v;
  logic        ins_rdy = 1'b0;
  logic [4:0]  op;
  logic        dup;
  logic [15:0] kval;
  logic        kvld;
  logic        call;
  logic [15:0] tgt;
  logic [2:0]  len;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_predecode uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .byte_valid_i(byte_v),
    .byte_ready_o(byte_rdy), .ins_valid_o(ins_v), .ins_ready_i(ins_rdy),
    .op_o(op), .dup_o(dup), .const_o(kval), .const_valid_o(kvld),
    .call_o(call), .call_target_o(tgt), .len_o(len)
  );

  // reference model state
  logic [7:0] stream[$];
  logic [7:0] m_buf[$];
  bit         m_vld = 0;
  logic [4:0] e_op; bit e_dup; logic [15:0] e_k; bit e_kv; bit e_call;
  logic [15:0] e_tgt; int e_len;
  int         n_ins = 0;

  function automatic int need_of(logic [7:0] b);
    if (b[7]) return 2;
    if (b[6:5] == 2'b11) return 4;
    return 2;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // model advances at each edge on the inputs driven before it
  always @(posedge clk) begin
    if (rst_n) begin
      bit rdy;
      rdy = !m_vld || ins_rdy;
      if (m_vld && ins_rdy) m_vld = 0;
      if (byte_v && rdy) begin
        m_buf.push_back(stream.pop_front());
        if (m_buf.size() == need_of(m_buf[0])) begin
          logic [7:0] b0;
          b0 = m_buf[0];
          e_len = m_buf.size();
          e_call = b0[7]; e_op = 0; e_dup = 0; e_k = 0; e_kv = 0; e_tgt = 0;
          if (e_call) e_tgt = {b0[6:0], m_buf[1], 1'b0};
          else begin
            e_op = b0[4:0];
            e_dup = (b0[6:5] == 2'b01);
            if (b0[6:5] == 2'b10) begin e_kv = 1; e_k = {{8{m_buf[1][7]}}, m_buf[1]}; end
            if (b0[6:5] == 2'b11) begin e_kv = 1; e_k = {m_buf[2], m_buf[1]}; end
          end
          m_buf.delete();
          m_vld = 1;
          n_ins++;
        end
      end
    end
  end

  task automatic compare();
    check("R8", "byte_ready", byte_rdy, !m_vld || ins_rdy);
    check("R9", "ins_valid", ins_v, m_vld);
    if (m_vld && ins_v) begin
      string rq;
      rq = e_call ? "R6" : (e_kv ? (e_len == 4 ? "R5" : "R4") : (e_dup ? "R3" : "R2"));
      check(rq, "op", op, e_op);
      check("R3", "dup", dup, e_dup);
      check(rq, "const_valid", kvld, e_kv);
      if (e_kv) check(rq, "const", kval, e_k);
      check("R6", "call", call, e_call);
      if (e_call) check("R6", "target", tgt, e_tgt);
      check(rq, "len", len, e_len);
    end
  endtask

  task automatic add_ins(logic [7:0] b0);
    stream.push_back(b0);
    for (int i = 1; i < need_of(b0); i++) stream.push_back(8'($urandom));
  endtask

  task automatic run(int n, int pv, int pr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      byte_v  = (stream.size() != 0) && (($urandom % 100) < pv);
      byte_d  = (stream.size() != 0) ? stream[0] : 8'h00;
      ins_rdy = (($urandom % 100) < pr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2);
    @(negedge clk);
    check("R1", "ins_valid in reset", ins_v, 0);
    check("R1", "byte_ready in reset", byte_rdy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ins_valid after reset", ins_v, 0);
    check("R1", "byte_ready after reset", byte_rdy, 1);

    // directed: plain, dup, k8 neg/pos, k16, call extremes
    stream = '{8'h05, 8'hFF, 8'h3A, 8'hA5, 8'h47, 8'h80, 8'h41, 8'h7F,
               8'h63, 8'h34, 8'h92, 8'hEE, 8'h9A, 8'hBC, 8'hFF, 8'hFF,
               8'h80, 8'h00, 8'h1F, 8'h00};
    run(80, 100, 100);
    run(120, 60, 30);
    for (int i = 0; i < 400; i++) add_ins(8'($urandom));
    run(1500, 70, 60);
    for (int i = 0; i < 300; i++) add_ins(8'($urandom));
    run(1200, 100, 100);
    for (int i = 0; i < 200; i++) add_ins(8'($urandom));
    run(1500, 40, 15);
    run(200, 100, 100);
    check("R8", "stream drained", stream.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule